// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block keeps the always-on state of a small microcontroller and steps it between a run state and three graded low-power states: a light sleep that gates only the core clock, a deep sleep that also powers down the analog blocks, and a power-down that removes the main power domain. Software picks the target depth through a mode field and raises a sleep request. The request is held until the core reports idle, and the move then takes exactly one clock. Each depth has its own set of wake sources. On the way back to run, the block records which state was left and why.

The block also holds a small bank of retention registers that survive power-down. It owns the clock-source select. That select falls back to the internal RC oscillator after power-on, after a power-down exit and after a chip reset. Before deep sleep is entered, the block checks that the clock source is safe for that depth. The active-low wake pin passes through a synchronizer and a glitch qualifier before it can end a power-down.

Top module: `pwr_mode_seq`

## Requirements
- R1: After power-on reset (por_n low), cur_mode is 0 (run), core_clk_en=1, main_pwr_en=1, analog_off=0, clk_src_sel=0 (RC oscillator), every retention register reads 0, and stat_last_mode, stat_wake_src and stat_entry_err are all 0.
- R2: A sleep_req pulse is remembered until core_idle is high. The state changes at the first clock edge where both the request (new or remembered) and core_idle are seen. While core_idle is low the state stays run. mode_sel codes: 0 and 3 give sleep, 1 gives deep sleep, 2 gives power-down. cur_mode codes: 0 run, 1 sleep, 2 deep sleep, 3 power-down.
- R3: In sleep, core_clk_en=0 while main_pwr_en=1, analog_off=0, wdosc_on=1 and bod_on=1. Sleep is left for run one edge after irq_pend is seen high.
- R4: In deep sleep, analog_off=1 and core_clk_en=0. wdosc_on and bod_on equal keep_wdosc and keep_bod as sampled at the entry edge, and later changes to those inputs have no effect until the next entry.
- R5: Deep sleep is left only when some bit i has both wake_gpio[i] and gpio_wake_en[i] high, or when rtc_match is high, or on chip_rst. irq_pend has no effect in deep sleep.
- R6: A deep-sleep request is refused when clk_src_sel is not 0 and keep_wdosc is 0. The state stays run and stat_entry_err becomes 1.
- R7: In power-down, main_pwr_en=0, analog_off=1, wdosc_on=0 and bod_on=0. Only a qualified wake pin or rtc_match ends it. irq_pend, the GPIO wake inputs and chip_rst have no effect.
- R8: wake_pin_n is active low. It passes two synchronizer flops, and two consecutive low synchronized samples are needed. A pin held low from before edge k gives run at edge k+3. A low pulse lasting one clock does not end power-down.
- R9: clk_src_sel is set to 0 on power-on reset, on chip_rst outside power-down, and on the edge that leaves power-down. A clk_src_wr write takes effect only in run.
- R10: The retention registers can be written only in run. They keep their values through sleep, deep sleep, power-down and chip_rst, and only por_n clears them.
- R11: On each exit to run, stat_last_mode takes the cur_mode code of the state that was left, and stat_wake_src takes the cause (1 interrupt, 2 GPIO, 3 RTC match, 4 wake pin, 5 chip reset). A stat_clr pulse clears all status fields. If an exit or a refusal happens in the same cycle as stat_clr, the event is recorded.
- R12: chip_rst returns sleep or deep sleep to run with wake source 5. In run it drops a remembered request.
- R13: The wake sources are tested in priority order. In deep sleep, chip reset beats GPIO and GPIO beats RTC. In power-down, the wake pin beats RTC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| chip_rst | input | 1 | Synchronous chip reset request |
| mode_sel | input | 2 | Requested low-power depth |
| keep_wdosc | input | 1 | Keep watchdog oscillator in deep sleep |
| keep_bod | input | 1 | Keep brownout detector in deep sleep |
| sleep_req | input | 1 | Sleep request strobe |
| core_idle | input | 1 | Core idle handshake |
| irq_pend | input | 1 | Any enabled interrupt pending |
| wake_gpio | input | 12 | Wake-capable GPIO levels |
| gpio_wake_en | input | 12 | Per-pin GPIO wake enable |
| rtc_match | input | 1 | RTC match event |
| wake_pin_n | input | 1 | Dedicated wake pin, active low |
| clk_src_wr | input | 1 | Clock-source select write strobe |
| clk_src_wdata | input | 2 | Clock-source code (0 RC, 1 system osc, 2 PLL, 3 watchdog osc) |
| ret_wr | input | 1 | Retention register write strobe |
| ret_waddr | input | 2 | Retention write index |
| ret_wdata | input | 32 | Retention write data |
| ret_raddr | input | 2 | Retention read index |
| ret_rdata | output | 32 | Retention read data |
| stat_clr | input | 1 | Status clear strobe |
| core_clk_en | output | 1 | Core clock gate enable |
| analog_off | output | 1 | Analog shutdown enable |
| wdosc_on | output | 1 | Watchdog oscillator enable |
| bod_on | output | 1 | Brownout detector enable |
| main_pwr_en | output | 1 | Main power-domain enable |
| clk_src_sel | output | 2 | Clock-source select |
| cur_mode | output | 2 | Current state code |
| stat_last_mode | output | 2 | State last exited |
| stat_wake_src | output | 3 | Cause of last exit |
| stat_entry_err | output | 1 | Deep-sleep entry refused |

## Verification
The hardest case to reach is a deep-sleep request that arrives while a non-RC clock is selected and the watchdog oscillator is not kept. To get there, the stimulus first writes a PLL code into the clock select while in run, then raises the request with keep_wdosc low. A second hard case is a one-cycle low pulse on the wake pin during power-down, which must not end it. The bench places that pulse between negedges, so exactly one synchronized sample is low, and only then holds the pin low to measure the three-edge exit latency. A behavioural model of all of this is compared with every output on every clock.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      PM_RUN    = 2'd0,
      PM_SLEEP  = 2'd1,
      PM_DSLEEP = 2'd2,
      PM_DPD    = 2'd3
   } pm_state_e;

   typedef enum logic [2:0] {
      WS_NONE  = 3'd0,
      WS_IRQ   = 3'd1,
      WS_GPIO  = 3'd2,
      WS_RTC   = 3'd3,
      WS_PIN   = 3'd4,
      WS_RESET = 3'd5
   } wake_src_e;

   localparam logic [1:0] CLK_IRC = 2'd0;

   localparam logic [1:0] MSEL_DSLEEP = 2'd1;
   localparam logic [1:0] MSEL_DPD    = 2'd2;

endpackage

// File: rtl/pwr_wake_pin.sv
module pwr_wake_pin #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_LEN    = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic wake_ok
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwr_wake_pin: SYNC_STAGES must be at least 2");
   end
   if (QUAL_LEN < 1) begin : g_bad_qual
      $error("pwr_wake_pin: QUAL_LEN must be at least 1");
   end

   // sync_q[0] is the newest sample, sync_q[LAST] the synchronized one
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '1;
      else        sync_q <= SYNC_STAGES'({sync_q, pin_n});
   end

   if (QUAL_LEN == 1) begin : g_single
      assign wake_ok = ~sync_q[LAST];
   end else begin : g_multi
      localparam int HL = QUAL_LEN - 1;
      logic [HL-1:0] hist_q;

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) hist_q <= '1;
         else        hist_q <= HL'({hist_q, sync_q[LAST]});
      end

      assign wake_ok = ~(|hist_q) & ~sync_q[LAST];

      AST_PIN_GLITCH: assert property (@(posedge clk) disable iff (!por_n)
         sync_q[LAST] |=> !wake_ok); // R8
   end

endmodule

// File: rtl/pwr_wake_sel.sv
module pwr_wake_sel
   import pwr_seq_pkg::*;
#(
   parameter int NUM_GPIO_WAKE = 12
) (
   input  pm_state_e               state,
   input  logic                    chip_rst,
   input  logic                    irq_pend,
   input  logic [NUM_GPIO_WAKE-1:0] gpio_lvl,
   input  logic [NUM_GPIO_WAKE-1:0] gpio_en,
   input  logic                    rtc_match,
   input  logic                    pin_ok,
   output logic                    wake_hit,
   output wake_src_e               wake_code
);

   logic gpio_hit;
   assign gpio_hit = |(gpio_lvl & gpio_en);

   always_comb begin
      wake_hit  = 1'b0;
      wake_code = WS_NONE;
      case (state)
         PM_SLEEP: begin
            if (chip_rst) begin
               wake_hit = 1'b1; wake_code = WS_RESET;
            end else if (irq_pend) begin
               wake_hit = 1'b1; wake_code = WS_IRQ;
            end
         end
         PM_DSLEEP: begin
            if (chip_rst) begin
               wake_hit = 1'b1; wake_code = WS_RESET;
            end else if (gpio_hit) begin
               wake_hit = 1'b1; wake_code = WS_GPIO;
            end else if (rtc_match) begin
               wake_hit = 1'b1; wake_code = WS_RTC;
            end
         end
         PM_DPD: begin
            if (pin_ok) begin
               wake_hit = 1'b1; wake_code = WS_PIN;
            end else if (rtc_match) begin
               wake_hit = 1'b1; wake_code = WS_RTC;
            end
         end
         default: begin
            wake_hit  = 1'b0;
            wake_code = WS_NONE;
         end
      endcase
   end

endmodule

// File: rtl/pwr_ret_bank.sv
module pwr_ret_bank #(
   parameter int RET_N  = 4,
   parameter int RET_W  = 32,
   parameter int RET_AW = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [RET_AW-1:0] waddr,
   input  logic [RET_W-1:0]  wdata,
   input  logic [RET_AW-1:0] raddr,
   output logic [RET_W-1:0]  rdata
);

   if (RET_N < 1 || RET_W < 1) begin : g_bad_size
      $error("pwr_ret_bank: RET_N and RET_W must be positive");
   end
   if ((1 << RET_AW) < RET_N) begin : g_bad_aw
      $error("pwr_ret_bank: RET_AW too narrow for RET_N");
   end

   logic [RET_N-1:0][RET_W-1:0] cell_vec;

   for (genvar g = 0; g < RET_N; g++) begin : g_cell
      logic [RET_W-1:0] cell_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                              cell_q <= '0;
         else if (wr_en && waddr == RET_AW'(g))   cell_q <= wdata;
      end
      assign cell_vec[g] = cell_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < RET_N; i++) begin
         if (raddr == RET_AW'(i)) rdata = cell_vec[i];
      end
   end

   AST_RET_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(cell_vec)); // R10

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_seq_pkg::*;
#(
   parameter int NUM_GPIO_WAKE = 12,
   parameter int SYNC_STAGES   = 2,
   parameter int PIN_QUAL_LEN  = 2,
   parameter int RET_N         = 4,
   parameter int RET_W         = 32,
   parameter int RET_AW        = (RET_N > 1) ? $clog2(RET_N) : 1
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     chip_rst,
   input  logic [1:0]               mode_sel,
   input  logic                     keep_wdosc,
   input  logic                     keep_bod,
   input  logic                     sleep_req,
   input  logic                     core_idle,
   input  logic                     irq_pend,
   input  logic [NUM_GPIO_WAKE-1:0] wake_gpio,
   input  logic [NUM_GPIO_WAKE-1:0] gpio_wake_en,
   input  logic                     rtc_match,
   input  logic                     wake_pin_n,
   input  logic                     clk_src_wr,
   input  logic [1:0]               clk_src_wdata,
   input  logic                     ret_wr,
   input  logic [RET_AW-1:0]        ret_waddr,
   input  logic [RET_W-1:0]         ret_wdata,
   input  logic [RET_AW-1:0]        ret_raddr,
   output logic [RET_W-1:0]         ret_rdata,
   input  logic                     stat_clr,
   output logic                     core_clk_en,
   output logic                     analog_off,
   output logic                     wdosc_on,
   output logic                     bod_on,
   output logic                     main_pwr_en,
   output logic [1:0]               clk_src_sel,
   output logic [1:0]               cur_mode,
   output logic [1:0]               stat_last_mode,
   output logic [2:0]               stat_wake_src,
   output logic                     stat_entry_err
);

   if (NUM_GPIO_WAKE < 1 || NUM_GPIO_WAKE > 32) begin : g_bad_gpio
      $error("pwr_mode_seq: NUM_GPIO_WAKE must be 1..32");
   end

   pm_state_e  state_q, state_d;
   logic       req_pend_q, req_pend_d;
   logic       keep_wd_q, keep_bod_q, latch_keep;
   logic [1:0] clk_src_q, clk_src_d;
   logic [1:0] last_q, last_d;
   logic [2:0] src_q, src_d;
   logic       err_q, err_d;
   logic       pin_ok, wake_hit, take, dsl_ok, refuse, ret_we;
   wake_src_e  wake_code;

   pwr_wake_pin #(
      .SYNC_STAGES (SYNC_STAGES),
      .QUAL_LEN    (PIN_QUAL_LEN)
   ) u_pin (
      .clk     (clk),
      .por_n   (por_n),
      .pin_n   (wake_pin_n),
      .wake_ok (pin_ok)
   );

   pwr_wake_sel #(
      .NUM_GPIO_WAKE (NUM_GPIO_WAKE)
   ) u_sel (
      .state     (state_q),
      .chip_rst  (chip_rst),
      .irq_pend  (irq_pend),
      .gpio_lvl  (wake_gpio),
      .gpio_en   (gpio_wake_en),
      .rtc_match (rtc_match),
      .pin_ok    (pin_ok),
      .wake_hit  (wake_hit),
      .wake_code (wake_code)
   );

   assign ret_we = ret_wr & (state_q == PM_RUN);

   pwr_ret_bank #(
      .RET_N  (RET_N),
      .RET_W  (RET_W),
      .RET_AW (RET_AW)
   ) u_ret (
      .clk   (clk),
      .por_n (por_n),
      .wr_en (ret_we),
      .waddr (ret_waddr),
      .wdata (ret_wdata),
      .raddr (ret_raddr),
      .rdata (ret_rdata)
   );

   // Sequencing
   assign take   = core_idle & (sleep_req | req_pend_q) & ~chip_rst & (state_q == PM_RUN);
   assign dsl_ok = (clk_src_q == CLK_IRC) | keep_wdosc;

   always_comb begin
      state_d    = state_q;
      req_pend_d = req_pend_q;
      latch_keep = 1'b0;
      refuse     = 1'b0;
      if (state_q == PM_RUN) begin
         if (chip_rst) begin
            req_pend_d = 1'b0;
         end else if (take) begin
            req_pend_d = 1'b0;
            if (mode_sel == MSEL_DPD) begin
               state_d = PM_DPD;
            end else if (mode_sel == MSEL_DSLEEP) begin
               if (dsl_ok) begin
                  state_d    = PM_DSLEEP;
                  latch_keep = 1'b1;
               end else begin
                  refuse = 1'b1;
               end
            end else begin
               state_d = PM_SLEEP;
            end
         end else if (sleep_req) begin
            req_pend_d = 1'b1;
         end
      end else if (wake_hit) begin
         state_d = PM_RUN;
      end
   end

   // Status capture
   always_comb begin
      last_d = last_q;
      src_d  = src_q;
      err_d  = err_q;
      if (stat_clr) begin
         last_d = '0;
         src_d  = '0;
         err_d  = 1'b0;
      end
      if (refuse) err_d = 1'b1;
      if (wake_hit && state_q != PM_RUN) begin
         last_d = state_q;
         src_d  = wake_code;
      end
   end

   // Clock-source select
   always_comb begin
      clk_src_d = clk_src_q;
      if (chip_rst && state_q != PM_DPD)         clk_src_d = CLK_IRC;
      else if (wake_hit && state_q == PM_DPD)    clk_src_d = CLK_IRC;
      else if (clk_src_wr && state_q == PM_RUN)  clk_src_d = clk_src_wdata;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q    <= PM_RUN;
         req_pend_q <= 1'b0;
         keep_wd_q  <= 1'b0;
         keep_bod_q <= 1'b0;
         clk_src_q  <= CLK_IRC;
         last_q     <= '0;
         src_q      <= '0;
         err_q      <= 1'b0;
      end else begin
         state_q    <= state_d;
         req_pend_q <= req_pend_d;
         clk_src_q  <= clk_src_d;
         last_q     <= last_d;
         src_q      <= src_d;
         err_q      <= err_d;
         if (latch_keep) begin
            keep_wd_q  <= keep_wdosc;
            keep_bod_q <= keep_bod;
         end
      end
   end

   // Output decode
   always_comb begin
      core_clk_en = 1'b0;
      analog_off  = 1'b1;
      wdosc_on    = 1'b0;
      bod_on      = 1'b0;
      main_pwr_en = 1'b1;
      case (state_q)
         PM_RUN, PM_SLEEP: begin
            core_clk_en = (state_q == PM_RUN);
            analog_off  = 1'b0;
            wdosc_on    = 1'b1;
            bod_on      = 1'b1;
         end
         PM_DSLEEP: begin
            wdosc_on = keep_wd_q;
            bod_on   = keep_bod_q;
         end
         default: begin
            main_pwr_en = 1'b0;
         end
      endcase
   end

   assign clk_src_sel    = clk_src_q;
   assign cur_mode       = state_q;
   assign stat_last_mode = last_q;
   assign stat_wake_src  = src_q;
   assign stat_entry_err = err_q;

   AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_RUN && !core_idle) |=> state_q == PM_RUN); // R2
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_SLEEP && !irq_pend && !chip_rst) |=> state_q == PM_SLEEP); // R3
   AST_DSLEEP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_DSLEEP && !chip_rst && !(|(wake_gpio & gpio_wake_en)) && !rtc_match)
      |=> state_q == PM_DSLEEP); // R5
   AST_DSLEEP_ENTRY_CLK: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_DSLEEP && $past(state_q) == PM_RUN)
      |-> ($past(clk_src_q) == CLK_IRC || keep_wd_q)); // R6
   AST_DPD_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_DPD && !pin_ok && !rtc_match) |=> state_q == PM_DPD); // R7
   AST_DPD_EXIT_IRC: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_RUN && $past(state_q) == PM_DPD) |-> clk_src_q == CLK_IRC); // R9
   AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
      (stat_clr && !refuse && !wake_hit) |=> (last_q == 2'd0 && src_q == 3'd0 && !err_q)); // R11

endmodule

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;

   logic        clk = 1'b0;
   logic        por_n, chip_rst, keep_wdosc, keep_bod, sleep_req, core_idle, irq_pend;
   logic [1:0]  mode_sel, clk_src_wdata;
   logic [11:0] wake_gpio, gpio_wake_en;
   logic        rtc_match, wake_pin_n, clk_src_wr, ret_wr, stat_clr;
   logic [1:0]  ret_waddr, ret_raddr;
   logic [31:0] ret_wdata, ret_rdata;
   logic        core_clk_en, analog_off, wdosc_on, bod_on, main_pwr_en, stat_entry_err;
   logic [1:0]  clk_src_sel, cur_mode, stat_last_mode;
   logic [2:0]  stat_wake_src;

   int n_chk = 0;
   int n_err = 0;
   bit cmp_en = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pwr_mode_seq u_pwr_mode_seq (
      .clk(clk), .por_n(por_n), .chip_rst(chip_rst), .mode_sel(mode_sel),
      .keep_wdosc(keep_wdosc), .keep_bod(keep_bod), .sleep_req(sleep_req),
      .core_idle(core_idle), .irq_pend(irq_pend), .wake_gpio(wake_gpio),
      .gpio_wake_en(gpio_wake_en), .rtc_match(rtc_match), .wake_pin_n(wake_pin_n),
      .clk_src_wr(clk_src_wr), .clk_src_wdata(clk_src_wdata), .ret_wr(ret_wr),
      .ret_waddr(ret_waddr), .ret_wdata(ret_wdata), .ret_raddr(ret_raddr),
      .ret_rdata(ret_rdata), .stat_clr(stat_clr), .core_clk_en(core_clk_en),
      .analog_off(analog_off), .wdosc_on(wdosc_on), .bod_on(bod_on),
      .main_pwr_en(main_pwr_en), .clk_src_sel(clk_src_sel), .cur_mode(cur_mode),
      .stat_last_mode(stat_last_mode), .stat_wake_src(stat_wake_src),
      .stat_entry_err(stat_entry_err)
   );

   task automatic chk(string rq, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   int m_st, m_pend, m_kwd, m_kbod, m_clk, m_last, m_src, m_err;
   int m_ret[4];
   bit pq[$];

   always @(posedge clk or negedge por_n) begin
      int st, nsrc;
      bit pin_w, gh;
      if (!por_n) begin
         m_st = 0; m_pend = 0; m_kwd = 0; m_kbod = 0; m_clk = 0;
         m_last = 0; m_src = 0; m_err = 0;
         foreach (m_ret[i]) m_ret[i] = 0;
         pq = '{1'b1, 1'b1, 1'b1};
      end else begin
         st    = m_st;
         nsrc  = 0;
         pin_w = (pq[1] == 1'b0) && (pq[2] == 1'b0);
         gh    = |(wake_gpio & gpio_wake_en);
         if (stat_clr) begin m_last = 0; m_src = 0; m_err = 0; end
         if (st == 0) begin
            if (chip_rst) m_pend = 0;
            else if ((sleep_req || m_pend) && core_idle) begin
               m_pend = 0;
               if (mode_sel == 2) m_st = 3;
               else if (mode_sel == 1) begin
                  if (m_clk == 0 || keep_wdosc) begin
                     m_st = 2; m_kwd = keep_wdosc; m_kbod = keep_bod;
                  end else m_err = 1;
               end else m_st = 1;
            end else if (sleep_req) m_pend = 1;
         end else if (st == 1) begin
            if (chip_rst) nsrc = 5; else if (irq_pend) nsrc = 1;
         end else if (st == 2) begin
            if (chip_rst) nsrc = 5; else if (gh) nsrc = 2; else if (rtc_match) nsrc = 3;
         end else begin
            if (pin_w) nsrc = 4; else if (rtc_match) nsrc = 3;
         end
         if (nsrc != 0) begin m_st = 0; m_last = st; m_src = nsrc; end
         if (chip_rst && st != 3) m_clk = 0;
         else if (nsrc != 0 && st == 3) m_clk = 0;
         else if (clk_src_wr && st == 0) m_clk = clk_src_wdata;
         if (ret_wr && st == 0) m_ret[ret_waddr] = ret_wdata;
         pq.push_front(wake_pin_n);
         void'(pq.pop_back());
      end
   end

   always @(posedge clk) begin
      #1;
      if (cmp_en && !done) begin
         chk("R2 cur_mode", cur_mode, m_st);
         chk("R3 core_clk_en", core_clk_en, m_st == 0);
         chk("R4 analog_off", analog_off, m_st >= 2);
         chk("R4 wdosc_on", wdosc_on, m_st < 2 ? 1 : (m_st == 2 ? m_kwd : 0));
         chk("R4 bod_on", bod_on, m_st < 2 ? 1 : (m_st == 2 ? m_kbod : 0));
         chk("R7 main_pwr_en", main_pwr_en, m_st != 3);
         chk("R9 clk_src_sel", clk_src_sel, m_clk);
         chk("R11 last_mode", stat_last_mode, m_last);
         chk("R11 wake_src", stat_wake_src, m_src);
         chk("R6 entry_err", stat_entry_err, m_err);
         chk("R10 ret_rdata", int'(ret_rdata), m_ret[ret_raddr]);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_req();
      sleep_req = 1; cyc(1); sleep_req = 0;
   endtask

   task automatic wr_clk(logic [1:0] v);
      clk_src_wr = 1; clk_src_wdata = v; cyc(1); clk_src_wr = 0;
   endtask

   initial begin
      #(20000 * 5);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      por_n = 0; chip_rst = 0; mode_sel = 0; keep_wdosc = 0; keep_bod = 0;
      sleep_req = 0; core_idle = 0; irq_pend = 0; wake_gpio = '0; gpio_wake_en = '0;
      rtc_match = 0; wake_pin_n = 1; clk_src_wr = 0; clk_src_wdata = 0; ret_wr = 0;
      ret_waddr = 0; ret_wdata = 0; ret_raddr = 2; stat_clr = 0;
      cyc(3);
      por_n = 1; cmp_en = 1;
      cyc(1);
      // R1 reset state
      chk("R1 mode", cur_mode, 0);
      chk("R1 core_clk", core_clk_en, 1);
      chk("R1 clk_src", clk_src_sel, 0);
      chk("R1 main_pwr", main_pwr_en, 1);
      chk("R1 ret", int'(ret_rdata), 0);
      chk("R1 status", {stat_last_mode, stat_wake_src, stat_entry_err}, 0);

      // R10 retention write in run
      ret_wr = 1; ret_waddr = 2; ret_wdata = 32'h5A5A1234; cyc(1); ret_wr = 0;
      chk("R10 ret write", int'(ret_rdata), 32'h5A5A1234);

      // R2 request held until idle
      mode_sel = 0; pulse_req(); cyc(3);
      chk("R2 waits idle", cur_mode, 0);
      core_idle = 1; cyc(1);
      chk("R2 taken on idle", cur_mode, 1);
      chk("R3 core gated", core_clk_en, 0);
      chk("R3 power kept", main_pwr_en, 1);
      chk("R3 analog on", analog_off, 0);
      ret_wr = 1; ret_wdata = 32'h0000DEAD; cyc(1); ret_wr = 0;
      wr_clk(2'd2);
      chk("R9 write ignored in sleep", clk_src_sel, 0);
      irq_pend = 1; cyc(1); irq_pend = 0;
      chk("R3 irq wake", cur_mode, 0);
      chk("R11 last sleep", stat_last_mode, 1);
      chk("R11 src irq", stat_wake_src, 1);
      chk("R10 sleep write ignored", int'(ret_rdata), 32'h5A5A1234);
      stat_clr = 1; cyc(1); stat_clr = 0;
      chk("R11 cleared", {stat_last_mode, stat_wake_src}, 0);

      // R6 refusal
      wr_clk(2'd2);
      chk("R9 run write", clk_src_sel, 2);
      mode_sel = 1; keep_wdosc = 0; pulse_req();
      chk("R6 refused", cur_mode, 0);
      chk("R6 err flag", stat_entry_err, 1);
      wr_clk(2'd0);

      // R4 deep sleep with watchdog oscillator kept
      keep_wdosc = 1; keep_bod = 0; pulse_req();
      chk("R4 in deep sleep", cur_mode, 2);
      chk("R4 analog off", analog_off, 1);
      chk("R4 wdosc kept", wdosc_on, 1);
      chk("R4 bod off", bod_on, 0);
      keep_wdosc = 0; cyc(1);
      chk("R4 latched keep", wdosc_on, 1);
      irq_pend = 1; cyc(2); irq_pend = 0;
      chk("R5 irq ignored", cur_mode, 2);
      wake_gpio = 12'h020; cyc(2);
      chk("R5 masked gpio", cur_mode, 2);
      gpio_wake_en = 12'h020; rtc_match = 1; cyc(1); rtc_match = 0;
      chk("R5 gpio wake", cur_mode, 0);
      chk("R13 gpio beats rtc", stat_wake_src, 2);
      wake_gpio = '0;

      keep_bod = 1; pulse_req();
      chk("R4 bod kept", bod_on, 1);
      chk("R4 wdosc off", wdosc_on, 0);
      rtc_match = 1; cyc(1); rtc_match = 0;
      chk("R5 rtc wake", stat_wake_src, 3);

      // R7/R8 power-down
      wr_clk(2'd1);
      mode_sel = 2; pulse_req();
      chk("R7 in power-down", cur_mode, 3);
      chk("R7 main off", main_pwr_en, 0);
      irq_pend = 1; wake_gpio = 12'h020; chip_rst = 1; cyc(2);
      irq_pend = 0; wake_gpio = '0; chip_rst = 0;
      chk("R7 others ignored", cur_mode, 3);
      chk("R12 reset ignored in power-down", clk_src_sel, 1);
      wake_pin_n = 0; cyc(1); wake_pin_n = 1; cyc(5);
      chk("R8 glitch rejected", cur_mode, 3);
      wake_pin_n = 0; rtc_match = 1; cyc(1); rtc_match = 0;
      chk("R13 rtc exit", cur_mode, 0);
      chk("R9 irc after exit", clk_src_sel, 0);
      wake_pin_n = 1; cyc(4);
      pulse_req();
      chk("R7 again", cur_mode, 3);
      wake_pin_n = 0; cyc(3);
      chk("R8 still down", cur_mode, 3);
      cyc(1);
      chk("R8 pin exit", cur_mode, 0);
      chk("R11 last power-down", stat_last_mode, 3);
      chk("R11 src pin", stat_wake_src, 4);
      chk("R10 retained", int'(ret_rdata), 32'h5A5A1234);
      wake_pin_n = 1; cyc(3);

      // R12 chip reset from sleep
      wr_clk(2'd2);
      mode_sel = 3; pulse_req();
      chk("R2 code 3 gives sleep", cur_mode, 1);
      chip_rst = 1; cyc(1); chip_rst = 0;
      chk("R12 reset wake", cur_mode, 0);
      chk("R12 src reset", stat_wake_src, 5);
      chk("R9 reset irc", clk_src_sel, 0);
      chk("R10 kept over reset", int'(ret_rdata), 32'h5A5A1234);

      // R1/R10 power-on clears
      cyc(1); por_n = 0; cyc(1); por_n = 1; cyc(1);
      chk("R10 por clears", int'(ret_rdata), 0);
      chk("R1 status after por", {stat_last_mode, stat_wake_src, stat_entry_err}, 0);
      cyc(2);

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule